// File: doc/BRIEF.md
# Qualified Sync Realignment of a Programmable Clock Divider

This block takes an asynchronous synchronization input, brings it into the fast input clock domain, and decides whether it counts as a qualified sync event. A qualified event resets the phase of a programmable clock divider, so that several such dividers driven from one sync line line up on the same output phase. The pin can be set to trigger on a high level, on a rising edge or on a falling edge.

A small register-style control word gates the path. A master enable must be set, and a divider-sync enable must be set as well. Continuous operation realigns on every qualified event. One-shot operation realigns once and then clears the divider-sync enable in hardware, so software reads it back as zero and can re-arm it by writing it again. A one-cycle strobe marks every realignment that actually takes place.

Top module: `syncdiv_align`

## Requirements
- R1: While control bit 0 (master enable) is 0, no sync input activity produces a realignment or a strobe on `align_stb`.
- R2: With bit 0 and bit 1 (divider-sync enable) both 1 and bit 2 (one-shot) 0, every qualified event realigns; with bit 1 at 0 nothing realigns.
- R3: With bits 0, 1 and 2 all 1, only the first qualified event realigns; later events are ignored until bit 1 is written to 1 again.
- R4: After a one-shot realignment, bit 1 of `ctl_rdata` reads 0 while the other control bits keep their written values.
- R5: With bit 3 (pin mode) at 0, a high level on the synchronized input is an event; the divider is held at phase zero and `align_stb` is high on every cycle the synchronized level stays high.
- R6: With bit 3 at 1, bit 4 selects the edge: 1 triggers on a rising edge, 0 on a falling edge; each edge gives exactly one strobe.
- R7: After reset all five control bits read 0 and `align_stb` is low.
- R8: A realignment forces the phase to zero with `div_clk` low; the next rising edge of `div_clk` comes exactly ratio/2 input cycles later. Free running, the output period is the ratio, and a ratio below 2 acts as 2.
- R9: A control write in the same cycle as a one-shot automatic clear wins: the written value of bit 1 is kept.
- R10: The input passes a two-flop synchronizer; the strobe for an input change driven between edges appears after the third following rising clock edge and lasts one cycle per realignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low reset |
| sync_raw | input | 1 | Asynchronous sync input |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 5 | Control word: bit0 master, bit1 divider-sync enable, bit2 one-shot, bit3 edge mode, bit4 rising polarity |
| div_ratio | input | RATIO_W | Divide ratio (even, values below 2 act as 2) |
| ctl_rdata | output | 5 | Current control word read-back |
| div_clk | output | 1 | Divided clock |
| align_stb | output | 1 | One-cycle realignment strobe |

## Verification
The sync input is driven with single pulses of several lengths under level, rising-edge and falling-edge settings, so the number and cycle of strobes tell level from edge and one polarity from the other. Pairs of pulses under continuous and one-shot settings separate repeated from single realignment, and pulses with either enable cleared show the gating. A control write timed onto the cycle of a one-shot clear shows which of the two wins, and divider ratios 6, 4 and 0 check the phase after realignment, the free-running period and the clamp.

// File: rtl/syncdiv_pkg.sv
package syncdiv_pkg;
   localparam int CTL_W = 5;

   // Control word layout, most significant field first
   typedef struct packed {
      logic rise_sel;   // bit 4: 1 rising, 0 falling
      logic edge_mode;  // bit 3: 1 edge, 0 level
      logic one_shot;   // bit 2
      logic div_en;     // bit 1
      logic master;     // bit 0
   } ctl_t;
endpackage

// File: rtl/syncdiv_cond.sv
module syncdiv_cond #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_raw,
   input  logic edge_mode,
   input  logic rise_sel,
   output logic evt
);
   localparam int LAST = STAGES - 1;

   initial begin
      assert (STAGES >= 2) else $error("syncdiv_cond: STAGES must be at least 2");
   end

   // pipe[0] is the first capture flop, pipe[LAST] the synchronized level,
   // pipe[STAGES] the previous synchronized level
   logic [STAGES:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-1:0], sync_raw};
   end

   logic cur, prv;
   assign cur = pipe[LAST];
   assign prv = pipe[STAGES];

   always_comb begin
      if (!edge_mode)    evt = cur;
      else if (rise_sel) evt = cur & ~prv;
      else               evt = ~cur & prv;
   end

   // R6
   edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && edge_mode) |=> !(evt && edge_mode && $stable(rise_sel)))
      else $error("edge event lasted more than one cycle");
endmodule

// File: rtl/syncdiv_ctl.sv
module syncdiv_ctl
   import syncdiv_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CTL_W-1:0] wdata,
   input  logic             consume,
   output ctl_t             ctl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctl <= '0;
      else if (we)      ctl <= ctl_t'(wdata);
      else if (consume) ctl.div_en <= 1'b0;
   end

   // R9
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (ctl == ctl_t'($past(wdata))))
      else $error("control write not taken");

   // R4
   auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (consume && !we) |=> (!ctl.div_en && $stable(ctl.master) && $stable(ctl.one_shot)))
      else $error("one-shot clear wrong");
endmodule

// File: rtl/syncdiv_phase.sv
module syncdiv_phase #(
   parameter int RW          = 8,
   parameter bit CLAMP_RATIO = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [RW-1:0] ratio,
   input  logic          realign,
   output logic          div_clk
);
   localparam logic [RW-1:0] MIN_RATIO = RW'(2);

   logic [RW-1:0] eff, half, cnt, nxt;

   generate
      if (CLAMP_RATIO) begin : g_clamp
         assign eff = (ratio < MIN_RATIO) ? MIN_RATIO : ratio;
      end else begin : g_raw
         assign eff = ratio;
      end
   endgenerate

   assign half = eff >> 1;
   assign nxt  = (cnt >= eff - 1'b1) ? '0 : cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         div_clk <= 1'b0;
      end else if (realign) begin
         cnt     <= '0;
         div_clk <= 1'b0;
      end else begin
         cnt     <= nxt;
         div_clk <= (nxt >= half);
      end
   end

   // R8
   realign_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      realign |=> (cnt == '0 && !div_clk))
      else $error("realign did not zero the phase");

   // R8
   rise_at_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(div_clk) && ratio == $past(ratio) && ratio == $past(ratio, 2)) |-> (cnt == half))
      else $error("divided clock rose off the half phase");
endmodule

// File: rtl/syncdiv_align.sv
module syncdiv_align
   import syncdiv_pkg::*;
#(
   parameter int RATIO_W     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk_in,
   input  logic               rst_n,
   input  logic               sync_raw,
   input  logic               ctl_we,
   input  logic [CTL_W-1:0]   ctl_wdata,
   input  logic [RATIO_W-1:0] div_ratio,
   output logic [CTL_W-1:0]   ctl_rdata,
   output logic               div_clk,
   output logic               align_stb
);
   initial begin
      assert (RATIO_W >= 2) else $error("syncdiv_align: RATIO_W must be at least 2");
   end

   ctl_t ctl;
   logic evt, realign, consume;

   syncdiv_cond #(.STAGES(SYNC_STAGES)) u_cond (
      .clk(clk_in), .rst_n(rst_n), .sync_raw(sync_raw),
      .edge_mode(ctl.edge_mode), .rise_sel(ctl.rise_sel), .evt(evt)
   );

   assign realign = evt & ctl.master & ctl.div_en;
   assign consume = realign & ctl.one_shot;

   syncdiv_ctl u_ctl (
      .clk(clk_in), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
      .consume(consume), .ctl(ctl)
   );

   syncdiv_phase #(.RW(RATIO_W)) u_phase (
      .clk(clk_in), .rst_n(rst_n), .ratio(div_ratio),
      .realign(realign), .div_clk(div_clk)
   );

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) align_stb <= 1'b0;
      else        align_stb <= realign;
   end

   assign ctl_rdata = ctl;

   // R1
   master_gate_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      !ctl_rdata[0] |=> !align_stb)
      else $error("strobe without master enable");

   // R8
   stb_low_clk_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      align_stb |-> !div_clk)
      else $error("divided clock high after realign");

   // R3
   one_shot_once_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      (align_stb && $past(ctl.one_shot) && !$past(ctl_we) && !ctl_we) |=> !align_stb)
      else $error("one-shot realigned twice");
endmodule

// File: tb/tb_syncdiv_align.sv
module tb_syncdiv_align;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_raw = 1'b0;
   logic       ctl_we = 1'b0;
   logic [4:0] ctl_wdata = '0;
   logic [7:0] div_ratio = 8'd4;
   logic [4:0] ctl_rdata;
   logic       div_clk, align_stb;

   syncdiv_align #(.RATIO_W(8), .SYNC_STAGES(2)) dut (
      .clk_in(clk), .rst_n(rst_n), .sync_raw(sync_raw), .ctl_we(ctl_we),
      .ctl_wdata(ctl_wdata), .div_ratio(div_ratio), .ctl_rdata(ctl_rdata),
      .div_clk(div_clk), .align_stb(align_stb)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0, errors = 0;
   int    exp_q[$];
   string tag_q[$];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic push(input int c, input string req);
      exp_q.push_back(c);
      tag_q.push_back(req);
   endtask

   // Monitor: every strobe must match the next expected cycle
   always @(negedge clk) begin
      int    c;
      string t;
      if (rst_n && align_stb) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R1/R2/R3 unexpected strobe", cyc, -1);
         end else begin
            c = exp_q.pop_front();
            t = tag_q.pop_front();
            check(c == cyc, t, cyc, c);
         end
      end
   end

   task automatic wr(input logic [4:0] v);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   // kind: 0 none, 1 one strobe at start+3, 2 one at fall+3, 3 one per high cycle
   task automatic pulse(input int len, input int kind, input string req);
      int n;
      @(negedge clk);
      n = cyc;
      if (kind == 1) push(n + 3, req);
      if (kind == 2) push(n + len + 3, req);
      if (kind == 3) for (int i = 0; i < len; i++) push(n + 3 + i, req);
      sync_raw = 1'b1;
      repeat (len) @(negedge clk);
      sync_raw = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic period(output int p);
      int a;
      while (div_clk) @(negedge clk);
      while (!div_clk) @(negedge clk);
      a = cyc;
      while (div_clk) @(negedge clk);
      while (!div_clk) @(negedge clk);
      p = cyc - a;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
   end

   initial begin
      int n, k, p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7 reset state
      check(ctl_rdata == 5'b0, "R7 control reset", ctl_rdata, 0);
      check(align_stb == 1'b0, "R7 strobe reset", align_stb, 0);
      pulse(3, 0, "R7 disabled after reset");

      // R1 master off
      wr(5'b11010);
      pulse(2, 0, "R1 master off");
      wr(5'b00010);
      pulse(4, 0, "R1 master off level");

      // R2 divider-sync enable off
      wr(5'b11001);
      pulse(2, 0, "R2 div enable off");

      // R5 level, continuous
      wr(5'b00011);
      pulse(1, 3, "R5 level len1");
      pulse(4, 3, "R5 level len4");

      // R6 rising edge, continuous, two pulses (R2)
      wr(5'b11011);
      pulse(3, 1, "R6 rising edge");
      pulse(5, 1, "R2 continuous second event");

      // R6 falling edge
      wr(5'b01011);
      pulse(3, 2, "R6 falling edge");

      // R3/R4 one-shot rising
      wr(5'b11111);
      pulse(2, 1, "R3 one-shot first");
      check(ctl_rdata == 5'b11101, "R4 auto clear readback", ctl_rdata, 5'b11101);
      pulse(2, 0, "R3 one-shot later ignored");

      // R3 one-shot in level mode: one strobe for a long level
      wr(5'b00111);
      pulse(5, 1, "R3 one-shot level");
      check(ctl_rdata == 5'b00101, "R4 auto clear level", ctl_rdata, 5'b00101);

      // R9 write on the cycle of the automatic clear
      wr(5'b11111);
      @(negedge clk);
      n = cyc;
      push(n + 3, "R9 event with write");
      sync_raw = 1'b1;
      @(negedge clk);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = 5'b11111;
      @(negedge clk);
      ctl_we = 1'b0;
      sync_raw = 1'b0;
      repeat (6) @(negedge clk);
      check(ctl_rdata == 5'b11111, "R9 write wins", ctl_rdata, 5'b11111);
      pulse(2, 1, "R9 still armed");
      check(ctl_rdata[1] == 1'b0, "R4 cleared after rearm", ctl_rdata[1], 0);

      // R8/R10 divider phase after realign, ratio 6
      div_ratio = 8'd6;
      wr(5'b11011);
      repeat (10) @(negedge clk);
      @(negedge clk);
      n = cyc;
      push(n + 3, "R10 latency");
      sync_raw = 1'b1;
      while (cyc < n + 3) @(negedge clk);
      check(align_stb == 1'b1, "R10 strobe at third edge", align_stb, 1);
      check(div_clk == 1'b0, "R8 output low on realign", div_clk, 0);
      k = 0;
      while (!div_clk && k < 20) begin
         @(negedge clk);
         k++;
      end
      check(k == 3, "R8 rise after ratio/2", k, 3);
      check(align_stb == 1'b0, "R10 strobe one cycle", align_stb, 0);
      sync_raw = 1'b0;
      repeat (6) @(negedge clk);

      period(p);
      check(p == 6, "R8 period ratio 6", p, 6);
      div_ratio = 8'd4;
      repeat (10) @(negedge clk);
      period(p);
      check(p == 4, "R8 period ratio 4", p, 4);
      div_ratio = 8'd0;
      repeat (10) @(negedge clk);
      period(p);
      check(p == 2, "R8 ratio clamp", p, 2);

      repeat (10) @(negedge clk);
      check(exp_q.size() == 0, "R10 missing strobes", exp_q.size(), 0);
      finish_run();
   end
endmodule